// File: doc/BRIEF.md
# Page Translation Cache with Access Rights Check

This block sits between a requester that issues virtual addresses and the memory system that wants physical ones. It holds a small set of fully associative entries. Each entry maps one 4 KB virtual page to a physical page and carries read, write and execute rights, together with a referenced status bit and a modified status bit. For each accepted request, every entry is compared with the virtual page number at the same time. The request then ends in one of three ways: a translated address, a page fault when no entry is present, or a protection fault when the entry does not permit the access type.

Software installs entries through a fill port, which writes one index per cycle. It can drop all entries at once with a flush input. It can also age all referenced bits at once with a clear input. The hardware keeps the status bits current: any permitted access marks its entry referenced, and a permitted write also marks it modified. A peek port reads back the state of one entry, so software can make replacement decisions.

Requests enter through a valid/ready handshake and leave through a registered valid/ready response. A request is accepted in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While a response is pending and `rsp_ready` is low, the response holds steady and no new request is accepted.

Top module: `xg_top`

## Requirements
- R1: A request whose page number matches no valid entry returns `rsp_page_fault`=1 and `rsp_prot_fault`=0, with `rsp_pa`=0.
- R2: A request that matches a valid entry whose right for the access type is clear returns `rsp_prot_fault`=1, `rsp_page_fault`=0 and `rsp_pa`=0. The access codes on `req_acc` are 0 for read, 1 for write and 2 for execute. Code 3 is never permitted.
- R3: A permitted request returns `rsp_pa` = {entry physical page, `req_va`[11:0]}, with both fault flags at 0.
- R4: A permitted request sets the referenced bit of the matched entry. A faulting request changes no status bit.
- R5: A permitted write sets the modified bit of the matched entry. Reads and executes leave that bit unchanged.
- R6: `clear_refs` clears every referenced bit in one cycle. A permitted access in the same cycle still leaves its own entry referenced.
- R7: A fill writes page numbers and rights into entry `fill_idx`, marks it valid, and clears its referenced and modified bits. The entry is visible to requests from the next cycle on. A fill takes precedence over a same-cycle access update to that entry.
- R8: `flush_all` clears every valid bit in one cycle, and takes precedence over a fill in the same cycle.
- R9: When several valid entries match, the entry with the lowest index supplies the translation and rights, and receives the status update.
- R10: The response to a request accepted at a clock edge appears with `rsp_valid`=1 right after that edge. It reflects the entries as they were before that edge. At most one fault flag is high.
- R11: `req_ready` is 1 exactly when no response is pending or `rsp_ready` is 1. A pending response that is not taken keeps its address and flags unchanged.
- R12: After reset no entry is valid, all status bits are 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_va | input | VA_W | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | PA_W | Physical address, 0 on a fault |
| rsp_page_fault | output | 1 | No valid entry matched |
| rsp_prot_fault | output | 1 | Access type not permitted |
| fill_en | input | 1 | Write one entry |
| fill_idx | input | IDX_W | Entry to write |
| fill_vpn | input | VA_W-12 | Virtual page number for the entry |
| fill_ppn | input | PA_W-12 | Physical page number for the entry |
| fill_r | input | 1 | Read right |
| fill_w | input | 1 | Write right |
| fill_x | input | 1 | Execute right |
| flush_all | input | 1 | Invalidate every entry |
| clear_refs | input | 1 | Clear every referenced bit |
| peek_idx | input | IDX_W | Entry to read back |
| peek_valid | output | 1 | Valid bit of that entry |
| peek_ref | output | 1 | Referenced bit of that entry |
| peek_dirty | output | 1 | Modified bit of that entry |

## Verification
The assertions check properties that must hold on every cycle. At most one fault flag is high. A faulting response carries a zero address. A stalled response stays stable. Every accepted request produces a response. After a flush, no entry is valid. A filled entry reads back clean. An aging pulse with no access in the same cycle clears every referenced bit. Only the bench's reference model can show the rest: translated addresses, the choice between page and protection fault, lowest-index selection among duplicate matches, and the exact timing of the status bits. It shows these by replaying directed scenarios and a random mix of fills, flushes, aging and stalls.

// File: rtl/xg_pkg.sv
package xg_pkg;
  localparam int unsigned PAGE_OFS_W = 12;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/xg_store.sv
module xg_store #(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill_en,
  input  logic [IDX_W-1:0]           fill_idx,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [PPN_W-1:0]           fill_ppn,
  input  logic                       fill_r,
  input  logic                       fill_w,
  input  logic                       fill_x,
  input  logic                       flush_all,
  input  logic                       clear_refs,
  input  logic                       upd_en,
  input  logic [IDX_W-1:0]           upd_idx,
  input  logic                       upd_wr,
  output logic [N-1:0]               ent_vld,
  output logic [N-1:0][VPN_W-1:0]    ent_vpn,
  output logic [N-1:0][PPN_W-1:0]    ent_ppn,
  output logic [N-1:0]               ent_r,
  output logic [N-1:0]               ent_w,
  output logic [N-1:0]               ent_x,
  output logic [N-1:0]               ent_ref,
  output logic [N-1:0]               ent_dirty
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             vld_q, r_q, w_q, x_q, ref_q, dirty_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             sel, hit_upd;

    assign sel     = fill_en && (fill_idx == IDX_W'(g));
    assign hit_upd = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q   <= 1'b0;
        r_q     <= 1'b0;
        w_q     <= 1'b0;
        x_q     <= 1'b0;
        ref_q   <= 1'b0;
        dirty_q <= 1'b0;
        vpn_q   <= '0;
        ppn_q   <= '0;
      end else begin
        if (flush_all)  vld_q <= 1'b0;
        else if (sel)   vld_q <= 1'b1;

        if (sel) begin
          vpn_q <= fill_vpn;
          ppn_q <= fill_ppn;
          r_q   <= fill_r;
          w_q   <= fill_w;
          x_q   <= fill_x;
        end

        if (sel)             ref_q <= 1'b0;
        else if (hit_upd)    ref_q <= 1'b1;
        else if (clear_refs) ref_q <= 1'b0;

        if (sel)                    dirty_q <= 1'b0;
        else if (hit_upd && upd_wr) dirty_q <= 1'b1;
      end
    end

    assign ent_vld[g]   = vld_q;
    assign ent_vpn[g]   = vpn_q;
    assign ent_ppn[g]   = ppn_q;
    assign ent_r[g]     = r_q;
    assign ent_w[g]     = w_q;
    assign ent_x[g]     = x_q;
    assign ent_ref[g]   = ref_q;
    assign ent_dirty[g] = dirty_q;
  end
endmodule

// File: rtl/xg_match.sv
module xg_match #(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 20,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [VPN_W-1:0]         vpn,
  input  logic [N-1:0]             ent_vld,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = ent_vld[g] && (ent_vpn[g] == vpn);
  end

  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xg_perm.sv
module xg_perm
  import xg_pkg::*;
(
  input  logic [1:0] acc,
  input  logic       r,
  input  logic       w,
  input  logic       x,
  output logic       allow,
  output logic       is_write
);
  always_comb begin
    unique case (acc_e'(acc))
      ACC_READ:  allow = r;
      ACC_WRITE: allow = w;
      ACC_EXEC:  allow = x;
      default:   allow = 1'b0;
    endcase
  end

  assign is_write = (acc_e'(acc) == ACC_WRITE);
endmodule

// File: rtl/xg_top.sv
module xg_top
  import xg_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned VPN_W = VA_W - PAGE_OFS_W,
  localparam int unsigned PPN_W = PA_W - PAGE_OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_page_fault,
  output logic             rsp_prot_fault,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_r,
  input  logic             fill_w,
  input  logic             fill_x,
  input  logic             flush_all,
  input  logic             clear_refs,
  input  logic [IDX_W-1:0] peek_idx,
  output logic             peek_valid,
  output logic             peek_ref,
  output logic             peek_dirty
);
  logic [N-1:0]              ent_vld, ent_r, ent_w, ent_x, ent_ref, ent_dirty;
  logic [N-1:0][VPN_W-1:0]   ent_vpn;
  logic [N-1:0][PPN_W-1:0]   ent_ppn;
  logic                      hit, allow, is_write, accept, granted;
  logic [IDX_W-1:0]          hit_idx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  xg_match #(.N(N), .VPN_W(VPN_W)) u_match (
    .vpn     (req_va[VA_W-1:PAGE_OFS_W]),
    .ent_vld (ent_vld),
    .ent_vpn (ent_vpn),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  xg_perm u_perm (
    .acc      (req_acc),
    .r        (ent_r[hit_idx]),
    .w        (ent_w[hit_idx]),
    .x        (ent_x[hit_idx]),
    .allow    (allow),
    .is_write (is_write)
  );

  assign granted = accept && hit && allow;

  xg_store #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .fill_r     (fill_r),
    .fill_w     (fill_w),
    .fill_x     (fill_x),
    .flush_all  (flush_all),
    .clear_refs (clear_refs),
    .upd_en     (granted),
    .upd_idx    (hit_idx),
    .upd_wr     (is_write),
    .ent_vld    (ent_vld),
    .ent_vpn    (ent_vpn),
    .ent_ppn    (ent_ppn),
    .ent_r      (ent_r),
    .ent_w      (ent_w),
    .ent_x      (ent_x),
    .ent_ref    (ent_ref),
    .ent_dirty  (ent_dirty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_pa         <= '0;
      rsp_page_fault <= 1'b0;
      rsp_prot_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid      <= 1'b1;
      rsp_page_fault <= !hit;
      rsp_prot_fault <= hit && !allow;
      rsp_pa         <= (hit && allow) ? {ent_ppn[hit_idx], req_va[PAGE_OFS_W-1:0]} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign peek_valid = ent_vld[peek_idx];
  assign peek_ref   = ent_ref[peek_idx];
  assign peek_dirty = ent_dirty[peek_idx];
endmodule

// File: rtl/xg_top_chk.sv
module xg_top_chk #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             rsp_page_fault,
  input logic             rsp_prot_fault,
  input logic             fill_en,
  input logic [IDX_W-1:0] fill_idx,
  input logic             flush_all,
  input logic             clear_refs,
  input logic [IDX_W-1:0] peek_idx,
  input logic             peek_valid,
  input logic             peek_ref,
  input logic             peek_dirty
);
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_page_fault && rsp_prot_fault)); // R10

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_pa == '0)); // R1

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa)
      && $stable(rsp_page_fault) && $stable(rsp_prot_fault))); // R11

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !peek_valid); // R8

  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_en && !flush_all) && (peek_idx == $past(fill_idx)))
      |-> (peek_valid && !peek_ref && !peek_dirty)); // R7

  AST_AGING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clear_refs) && !$past(req_valid && req_ready))
      |-> !peek_ref); // R6
endmodule

bind xg_top xg_top_chk #(.PA_W(PA_W), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_pa         (rsp_pa),
  .rsp_page_fault (rsp_page_fault),
  .rsp_prot_fault (rsp_prot_fault),
  .fill_en        (fill_en),
  .fill_idx       (fill_idx),
  .flush_all      (flush_all),
  .clear_refs     (clear_refs),
  .peek_idx       (peek_idx),
  .peek_valid     (peek_valid),
  .peek_ref       (peek_ref),
  .peek_dirty     (peek_dirty)
);

// File: tb/test_xg_top.sv
module test_xg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_pa;
  logic        rsp_page_fault, rsp_prot_fault;
  logic        fill_en = 1'b0;
  logic [2:0]  fill_idx = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_r = 1'b0, fill_w = 1'b0, fill_x = 1'b0;
  logic        flush_all = 1'b0;
  logic        clear_refs = 1'b0;
  logic [2:0]  peek_idx = '0;
  logic        peek_valid, peek_ref, peek_dirty;

  always #4 clk = ~clk;

  xg_top i_xg_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_r(fill_r), .fill_w(fill_w), .fill_x(fill_x), .flush_all(flush_all),
    .clear_refs(clear_refs), .peek_idx(peek_idx), .peek_valid(peek_valid),
    .peek_ref(peek_ref), .peek_dirty(peek_dirty)
  );

  int    checks = 0;
  int    failures = 0;
  string scn = "R12";

  // behavioural reference state
  bit          m_v[8], m_r[8], m_w[8], m_x[8], m_ref[8], m_dirty[8];
  bit [19:0]   m_vpn[8], m_ppn[8];
  bit          m_rv;
  bit [31:0]   m_pa;
  bit          m_pf, m_xf;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_v[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
      end
      m_rv = 0;
    end else begin
      bit take, ok;
      int hit;
      take = req_valid && (!m_rv || rsp_ready);
      hit = -1;
      ok = 0;
      for (int i = 0; i < 8; i++)
        if (hit < 0 && m_v[i] && m_vpn[i] == req_va[31:12]) hit = i;
      if (hit >= 0)
        ok = (req_acc == 0 && m_r[hit]) || (req_acc == 1 && m_w[hit]) ||
             (req_acc == 2 && m_x[hit]);
      if (take) begin
        m_rv = 1;
        m_pf = (hit < 0);
        m_xf = (hit >= 0) && !ok;
        m_pa = (hit >= 0 && ok) ? {m_ppn[hit], req_va[11:0]} : 32'h0;
      end else if (rsp_ready) m_rv = 0;
      if (clear_refs) for (int i = 0; i < 8; i++) m_ref[i] = 0;
      if (take && hit >= 0 && ok) begin
        m_ref[hit] = 1;
        if (req_acc == 1) m_dirty[hit] = 1;
      end
      if (fill_en) begin
        m_vpn[fill_idx] = fill_vpn; m_ppn[fill_idx] = fill_ppn;
        m_r[fill_idx] = fill_r; m_w[fill_idx] = fill_w; m_x[fill_idx] = fill_x;
        m_v[fill_idx] = 1; m_ref[fill_idx] = 0; m_dirty[fill_idx] = 0;
      end
      if (flush_all) for (int i = 0; i < 8; i++) m_v[i] = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (scenario %s) at %0t: actual=%h expected=%h", tag, scn, $time, act, exp);
    end
  endtask

  // compare away from the edge, after outputs and the model have settled
  always @(posedge clk) begin
    #2;
    chk("R11 req_ready", {31'b0, req_ready}, {31'b0, (!m_rv || rsp_ready)});
    chk("R10 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rv});
    if (m_rv) begin
      string t;
      t = m_pf ? "R1" : (m_xf ? "R2" : "R3");
      chk({t, " rsp_pa"}, rsp_pa, m_pa);
      chk({t, " page_fault"}, {31'b0, rsp_page_fault}, {31'b0, m_pf});
      chk({t, " prot_fault"}, {31'b0, rsp_prot_fault}, {31'b0, m_xf});
    end
    chk("R7 peek_valid", {31'b0, peek_valid}, {31'b0, m_v[peek_idx]});
    chk("R4 peek_ref", {31'b0, peek_ref}, {31'b0, m_ref[peek_idx]});
    chk("R5 peek_dirty", {31'b0, peek_dirty}, {31'b0, m_dirty[peek_idx]});
  end

  task automatic tick();
    @(negedge clk);
    peek_idx = peek_idx + 3'd1;
    req_valid = 0; fill_en = 0; flush_all = 0; clear_refs = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fill(input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic r, input logic w, input logic x);
    fill_en = 1; fill_idx = 3'(idx); fill_vpn = vpn; fill_ppn = ppn;
    fill_r = r; fill_w = w; fill_x = x;
    tick();
  endtask

  task automatic req(input logic [31:0] va, input logic [1:0] acc);
    req_valid = 1; req_va = va; req_acc = acc;
    tick();
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1;
        idle(9);
        scn = "R1";
        req(32'h0001_0abc, 2'd0);
        idle(2);
        scn = "R7";
        fill(0, 20'h00010, 20'h0a000, 1, 0, 0);
        fill(1, 20'h00011, 20'h0a001, 1, 1, 0);
        fill(2, 20'h00012, 20'h0a002, 0, 0, 1);
        fill(3, 20'h00013, 20'h0a003, 1, 1, 1);
        idle(8);
        scn = "R3";
        req(32'h0001_0123, 2'd0);
        req(32'h0001_1fff, 2'd1);
        req(32'h0001_2000, 2'd2);
        idle(8);
        scn = "R2";
        req(32'h0001_0004, 2'd1);
        req(32'h0001_1004, 2'd2);
        req(32'h0001_3004, 2'd3);
        req(32'h0001_2004, 2'd0);
        idle(8);
        scn = "R6";
        clear_refs = 1; tick();
        idle(8);
        clear_refs = 1; req(32'h0001_3010, 2'd0);
        idle(8);
        scn = "R9";
        fill(6, 20'h00055, 20'h0b006, 1, 1, 1);
        fill(5, 20'h00055, 20'h0b005, 1, 0, 0);
        req(32'h0005_5abc, 2'd0);
        req(32'h0005_5abc, 2'd1);
        idle(8);
        scn = "R7";
        fill(5, 20'h00077, 20'h0c005, 1, 1, 0);
        req(32'h0005_5000, 2'd1);
        fill_en = 1; fill_idx = 3'd6; fill_vpn = 20'h00055; fill_ppn = 20'h0d006;
        fill_r = 1; fill_w = 1; fill_x = 0;
        req(32'h0005_5000, 2'd1);
        idle(8);
        scn = "R11";
        rsp_ready = 0;
        req(32'h0001_1100, 2'd0);
        req_valid = 1; req_va = 32'h0001_0200; req_acc = 2'd0; tick();
        req_valid = 1; tick();
        rsp_ready = 1;
        req_valid = 1; req_va = 32'h0001_0300; tick();
        idle(3);
        scn = "R10";
        for (int i = 0; i < 6; i++) req({12'h000, 4'h1, 4'(i), 12'h0f0}, 2'(i % 3));
        idle(3);
        scn = "R8";
        fill_en = 1; fill_idx = 3'd7; fill_vpn = 20'h00099; fill_ppn = 20'h0e007;
        fill_r = 1; fill_w = 1; fill_x = 1; flush_all = 1;
        tick();
        idle(8);
        req(32'h0001_0000, 2'd0);
        req(32'h0009_9000, 2'd0);
        idle(3);
        scn = "random";
        for (int i = 0; i < 600; i++) begin
          rsp_ready = ($urandom % 4) != 0;
          if (($urandom % 5) == 0)
            begin
              fill_en = 1; fill_idx = 3'($urandom); fill_vpn = 20'h00020 + 20'($urandom % 6);
              fill_ppn = 20'($urandom); fill_r = 1'($urandom); fill_w = 1'($urandom);
              fill_x = 1'($urandom);
            end
          flush_all = ($urandom % 60) == 0;
          clear_refs = ($urandom % 15) == 0;
          req_valid = ($urandom % 3) != 0;
          req_va = {20'h00020 + 20'($urandom % 7), 12'($urandom)};
          req_acc = 2'($urandom);
          @(negedge clk);
          peek_idx = peek_idx + 3'd1;
        end
        rsp_ready = 1;
        idle(4);
      end
      begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule